// File: doc/BRIEF.md
# Keyed Configuration Register Space

This block is the configuration front end of a multi-function peripheral chip. The host reaches it through two byte-wide ports. The port at the base address carries keys and register indices. The port at base+1 carries register data. While locked, the block ignores everything except the opening key. After the opening byte has been written twice in a row to the base port, the block enters configuration mode. In that mode a base-port write picks a register index, and the data port reads or writes that register. A closing byte written to the base port locks the space again.

The register space has global registers: a device-select number, a fixed identity byte, a revision byte, and a read-only power view. It also has one bank of settings for each logical device. The device-select number chooses which bank the indices from 0x30 upward reach. Every bank has an activate flag, a 16-bit base address and a primary interrupt number. Only some devices have a secondary interrupt, a DMA channel, or the floppy mode and option bytes. The settings of every device leave the block as registered output vectors, which the peripheral blocks take as their configuration.

The unlock logic is one state machine with three states. `ST_RUN` is locked. `ST_HALF` means one opening key has been seen. `ST_CFG` is configuration mode. Its transitions are:
- `open1`: ST_RUN to ST_HALF, on a base write of 0x55.
- `open2`: ST_HALF to ST_CFG, on a base write of 0x55.
- `abort`: ST_HALF to ST_RUN, on any other write to either port.
- `close`: ST_CFG to ST_RUN, on a base write of 0xAA.

Every other cycle holds the current state. Idle cycles do not disturb a partial key.

Top module: `cfg_keyed_space`

## Requirements
- R1: After reset the block is locked (`cfg_mode` = 0), the data port reads 0xFF, and every device output is zero.
- R2: Configuration mode is entered only by two consecutive base-port writes of 0x55. A write of any other byte to either port after a single 0x55 returns the block to the locked state.
- R3: A base-port write of 0xAA in configuration mode locks the block. From then on the data port reads 0xFF.
- R4: While locked, data-port writes and base-port writes other than 0x55 change no register and no output, and data-port reads return 0xFF.
- R5: Index 0x20 reads 0x02 and index 0x21 reads the revision parameter (default 0x01). Writes to either index are ignored.
- R6: Index 0x07 holds a 4-bit device number, taken from the low four bits of the written byte. Indices 0x30 and above reach the bank of the selected device. With a number above 8, those indices read 0x00 and writes to them are ignored.
- R7: In each bank, index 0x30 bit 0 is the activate flag, 0x60 is the base-address high byte, 0x61 is the low byte, and 0x70 is the interrupt number. The outputs `dev_active[n]`, `dev_base[16n+:16]` = {high, low} and `dev_irq[8n+:8]` show the new value from the clock edge that takes the data write onward.
- R8: Index 0x72 is a read/write secondary interrupt byte for device 7 only. For other devices it reads 0x00 and ignores writes.
- R9: Index 0x74 is a DMA channel byte for devices 0 and 3 only, shown on `dev_dma[8n+:8]`. For other devices it reads 0x00, ignores writes, and their `dev_dma` field stays 0.
- R10: Indices 0x90 and 0x91 are full 8-bit read/write mode and option bytes for device 0 only. For other devices they read 0x00.
- R11: Index 0x22 reads the activate flags of devices 0 to 5 in bits 0 to 5, with bits 6 and 7 zero. Writes to it are ignored.
- R12: Any index not listed above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| port_sel | input | 1 | 0 = base (key/index) port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the port chosen by `port_sel` |
| cfg_mode | output | 1 | High while in configuration mode |
| dev_active | output | NUM_DEV | Activate flag of each device |
| dev_base | output | 16*NUM_DEV | Base address of each device |
| dev_irq | output | 8*NUM_DEV | Primary interrupt number of each device |
| dev_dma | output | 8*NUM_DEV | DMA channel of each device (0 where absent) |

## Verification
The assertions assume that `wr_en`, `port_sel` and `wdata` are stable around each rising edge, and that a read has no side effect, so `rdata` may be sampled at any time. The stimulus changes these inputs only just after a rising edge and samples outputs at the falling edge. It returns `wr_en` low between writes, so idle cycles sit between keys. This also shows that a partial key survives idle time and is cleared only by a different write.

// File: rtl/cfgks_pkg.sv
package cfgks_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALF = 2'd1,
        ST_CFG  = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_OPEN  = 8'h55;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;

    localparam logic [7:0] IX_LDN  = 8'h07;
    localparam logic [7:0] IX_ID   = 8'h20;
    localparam logic [7:0] IX_REV  = 8'h21;
    localparam logic [7:0] IX_PWR  = 8'h22;
    localparam logic [7:0] IX_ACT  = 8'h30;
    localparam logic [7:0] IX_BHI  = 8'h60;
    localparam logic [7:0] IX_BLO  = 8'h61;
    localparam logic [7:0] IX_IRQ  = 8'h70;
    localparam logic [7:0] IX_IRQ2 = 8'h72;
    localparam logic [7:0] IX_DMA  = 8'h74;
    localparam logic [7:0] IX_MODE = 8'h90;
    localparam logic [7:0] IX_OPT  = 8'h91;

    localparam int DEV_FLOPPY   = 0;
    localparam int DEV_PARALLEL = 3;
    localparam int DEV_KEYBOARD = 7;

endpackage

// File: rtl/cfgks_key_fsm.sv
module cfgks_key_fsm
    import cfgks_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       port_sel,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic       idx_we,
    output logic       data_we
);

    key_state_t state_q, state_d;

    logic base_wr;
    assign base_wr = wr_en && !port_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (base_wr && wdata == KEY_OPEN) state_d = ST_HALF;
            ST_HALF: if (wr_en) state_d = (base_wr && wdata == KEY_OPEN) ? ST_CFG : ST_RUN;
            ST_CFG:  if (base_wr && wdata == KEY_CLOSE) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        cfg_mode = (state_q == ST_CFG);
        idx_we   = cfg_mode && base_wr && (wdata != KEY_CLOSE);
        data_we  = cfg_mode && wr_en && port_sel;
    end

endmodule

// File: rtl/cfgks_dev_bank.sv
module cfgks_dev_bank
    import cfgks_pkg::*;
#(
    parameter bit HAS_IRQ2 = 1'b0,
    parameter bit HAS_DMA  = 1'b0,
    parameter bit HAS_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base,
    output logic [7:0]  irq,
    output logic [7:0]  dma,
    output logic [7:0]  rd_val
);

    logic       hit;
    logic       act_q;
    logic [7:0] bhi_q, blo_q, irq_q;
    logic [7:0] irq2_q, dma_q, mode_q, opt_q;

    assign hit = sel && wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            bhi_q <= '0;
            blo_q <= '0;
            irq_q <= '0;
        end else if (hit) begin
            if (idx == IX_ACT) act_q <= wdata[0];
            if (idx == IX_BHI) bhi_q <= wdata;
            if (idx == IX_BLO) blo_q <= wdata;
            if (idx == IX_IRQ) irq_q <= wdata;
        end
    end

    generate
        if (HAS_IRQ2) begin : g_irq2
            always_ff @(posedge clk) begin
                if (!rst_n)                    irq2_q <= '0;
                else if (hit && idx == IX_IRQ2) irq2_q <= wdata;
            end
        end else begin : g_no_irq2
            assign irq2_q = '0;
        end

        if (HAS_DMA) begin : g_dma
            always_ff @(posedge clk) begin
                if (!rst_n)                   dma_q <= '0;
                else if (hit && idx == IX_DMA) dma_q <= wdata;
            end
        end else begin : g_no_dma
            assign dma_q = '0;
        end

        if (HAS_MODE) begin : g_mode
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q <= '0;
                    opt_q  <= '0;
                end else if (hit) begin
                    if (idx == IX_MODE) mode_q <= wdata;
                    if (idx == IX_OPT)  opt_q  <= wdata;
                end
            end
        end else begin : g_no_mode
            assign mode_q = '0;
            assign opt_q  = '0;
        end
    endgenerate

    assign active = act_q;
    assign base   = {bhi_q, blo_q};
    assign irq    = irq_q;
    assign dma    = dma_q;

    always_comb begin
        rd_val = '0;
        if (sel) begin
            case (idx)
                IX_ACT:  rd_val = {7'b0, act_q};
                IX_BHI:  rd_val = bhi_q;
                IX_BLO:  rd_val = blo_q;
                IX_IRQ:  rd_val = irq_q;
                IX_IRQ2: rd_val = irq2_q;
                IX_DMA:  rd_val = dma_q;
                IX_MODE: rd_val = mode_q;
                IX_OPT:  rd_val = opt_q;
                default: rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_keyed_space.sv
module cfg_keyed_space
    import cfgks_pkg::*;
#(
    parameter int         NUM_DEV  = 9,
    parameter int         LDN_W    = 4,
    parameter int         PWR_DEVS = 6,
    parameter logic [7:0] ID_VAL   = 8'h02,
    parameter logic [7:0] REV_VAL  = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   port_sel,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic                   cfg_mode,
    output logic [NUM_DEV-1:0]     dev_active,
    output logic [NUM_DEV*16-1:0]  dev_base,
    output logic [NUM_DEV*8-1:0]   dev_irq,
    output logic [NUM_DEV*8-1:0]   dev_dma
);

    localparam int BYTE_W = 8;

    logic             idx_we, data_we;
    logic [7:0]       idx_q;
    logic [LDN_W-1:0] ldn_q;
    logic [7:0]       bank_rd [NUM_DEV];
    logic [7:0]       bank_or;
    logic [7:0]       reg_val;

    cfgks_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .port_sel (port_sel),
        .wdata    (wdata),
        .cfg_mode (cfg_mode),
        .idx_we   (idx_we),
        .data_we  (data_we)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ldn_q <= '0;
        end else begin
            if (idx_we) idx_q <= wdata;
            if (data_we && idx_q == IX_LDN) ldn_q <= wdata[LDN_W-1:0];
        end
    end

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
            cfgks_dev_bank #(
                .HAS_IRQ2 (d == DEV_KEYBOARD),
                .HAS_DMA  (d == DEV_FLOPPY || d == DEV_PARALLEL),
                .HAS_MODE (d == DEV_FLOPPY)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (ldn_q == LDN_W'(d)),
                .wr     (data_we),
                .idx    (idx_q),
                .wdata  (wdata),
                .active (dev_active[d]),
                .base   (dev_base[d*16 +: 16]),
                .irq    (dev_irq[d*BYTE_W +: BYTE_W]),
                .dma    (dev_dma[d*BYTE_W +: BYTE_W]),
                .rd_val (bank_rd[d])
            );
        end
    endgenerate

    always_comb begin
        bank_or = '0;
        for (int d = 0; d < NUM_DEV; d++) bank_or = bank_or | bank_rd[d];
    end

    always_comb begin
        case (idx_q)
            IX_LDN:  reg_val = 8'(ldn_q);
            IX_ID:   reg_val = ID_VAL;
            IX_REV:  reg_val = REV_VAL;
            IX_PWR:  reg_val = 8'(dev_active[PWR_DEVS-1:0]);
            default: reg_val = bank_or;
        endcase
        rdata = (cfg_mode && port_sel) ? reg_val : 8'hFF;
    end

endmodule

// File: rtl/cfg_keyed_space_chk.sv
module cfg_keyed_space_chk #(
    parameter int         NUM_DEV = 9,
    parameter logic [7:0] ID_VAL  = 8'h02
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  port_sel,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic                  cfg_mode,
    input logic [7:0]            idx_q,
    input logic [NUM_DEV-1:0]    dev_active,
    input logic [NUM_DEV*16-1:0] dev_base,
    input logic [NUM_DEV*8-1:0]  dev_irq,
    input logic [NUM_DEV*8-1:0]  dev_dma
);

    // R2
    key_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(wr_en && !port_sel && wdata == 8'h55));

    // R3
    key_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && wr_en && !port_sel && wdata == 8'hAA) |=> !cfg_mode);

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(dev_active) && $stable(dev_base) &&
                       $stable(dev_irq) && $stable(dev_dma)));

    // R5
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && port_sel && idx_q == 8'h20) |-> rdata == ID_VAL);

    // R11
    pwr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && port_sel && idx_q == 8'h22) |->
            (rdata[5:0] == dev_active[5:0] && rdata[7:6] == 2'b00));

    // R7
    out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_base) |-> $past(cfg_mode && wr_en && port_sel));

endmodule

bind cfg_keyed_space cfg_keyed_space_chk #(
    .NUM_DEV (NUM_DEV),
    .ID_VAL  (ID_VAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .port_sel   (port_sel),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_mode   (cfg_mode),
    .idx_q      (idx_q),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_irq    (dev_irq),
    .dev_dma    (dev_dma)
);

// File: tb/test_cfg_keyed_space.sv
`timescale 1ns/1ps
module test_cfg_keyed_space;

    localparam int ND = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          port_sel = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          cfg_mode;
    logic [ND-1:0] dev_active;
    logic [ND*16-1:0] dev_base;
    logic [ND*8-1:0]  dev_irq;
    logic [ND*8-1:0]  dev_dma;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cfg_keyed_space i_cfg_keyed_space (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode),
        .dev_active(dev_active), .dev_base(dev_base),
        .dev_irq(dev_irq), .dev_dma(dev_dma)
    );

    // behavioural reference: 0 locked, 1 half key, 2 configuration
    int mst, midx, mldn, mirq2, mmode, mopt;
    int mact[ND], mbhi[ND], mblo[ND], mirq[ND], mdma[ND];

    function automatic int mread(int ix);
        int v;
        v = 0;
        if (ix == 'h07) v = mldn;
        else if (ix == 'h20) v = 2;
        else if (ix == 'h21) v = 1;
        else if (ix == 'h22) begin
            for (int k = 0; k < 6; k++) v += mact[k] << k;
        end else if (ix >= 'h30 && mldn < ND) begin
            case (ix)
                'h30: v = mact[mldn];
                'h60: v = mbhi[mldn];
                'h61: v = mblo[mldn];
                'h70: v = mirq[mldn];
                'h72: v = (mldn == 7) ? mirq2 : 0;
                'h74: v = mdma[mldn];
                'h90: v = (mldn == 0) ? mmode : 0;
                'h91: v = (mldn == 0) ? mopt : 0;
                default: v = 0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; midx = 0; mldn = 0; mirq2 = 0; mmode = 0; mopt = 0;
            for (int k = 0; k < ND; k++) begin
                mact[k] = 0; mbhi[k] = 0; mblo[k] = 0; mirq[k] = 0; mdma[k] = 0;
            end
        end else if (wr_en) begin
            if (!port_sel) begin
                if (mst == 0) begin
                    if (wdata == 8'h55) mst = 1;
                end else if (mst == 1) mst = (wdata == 8'h55) ? 2 : 0;
                else if (wdata == 8'hAA) mst = 0;
                else midx = wdata;
            end else if (mst == 1) mst = 0;
            else if (mst == 2) begin
                if (midx == 'h07) mldn = wdata & 15;
                else if (midx >= 'h30 && mldn < ND) begin
                    case (midx)
                        'h30: mact[mldn] = wdata & 1;
                        'h60: mbhi[mldn] = wdata;
                        'h61: mblo[mldn] = wdata;
                        'h70: mirq[mldn] = wdata;
                        'h72: if (mldn == 7) mirq2 = wdata;
                        'h74: if (mldn == 0 || mldn == 3) mdma[mldn] = wdata;
                        'h90: if (mldn == 0) mmode = wdata;
                        'h91: if (mldn == 0) mopt = wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model cfg_mode", int'(cfg_mode), int'(mst == 2));
            chk("R4 model rdata", int'(rdata), (mst == 2 && port_sel) ? mread(midx) : 255);
            for (int d = 0; d < ND; d++) begin
                chk("R7 model active", int'(dev_active[d]), mact[d]);
                chk("R7 model base", int'(dev_base[d*16 +: 16]), (mbhi[d] << 8) | mblo[d]);
                chk("R7 model irq", int'(dev_irq[d*8 +: 8]), mirq[d]);
                chk("R9 model dma", int'(dev_dma[d*8 +: 8]), mdma[d]);
            end
        end
    end

    task automatic put(input bit p, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; port_sel = p; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic setr(input logic [7:0] ix, input logic [7:0] d);
        put(1'b0, ix);
        put(1'b1, d);
    endtask

    task automatic peek(input logic [7:0] ix, output int v);
        put(1'b0, ix);
        port_sel = 1'b1;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic summary;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=finished");
        summary();
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        port_sel = 1'b1;
        @(negedge clk);
        chk("R1 reset rdata", int'(rdata), 'hFF);
        chk("R1 reset cfg_mode", int'(cfg_mode), 0);
        chk("R1 reset outputs", int'(|{dev_active, dev_base, dev_irq, dev_dma}), 0);

        // R2: half key aborted by a data write, then by a wrong base byte
        put(0, 8'h55); put(1, 8'h00); put(0, 8'h55);
        @(negedge clk); chk("R2 abort by data write", int'(cfg_mode), 0);
        put(0, 8'h20);
        put(0, 8'h55);
        @(negedge clk); chk("R2 abort by other byte", int'(cfg_mode), 0);
        put(0, 8'h12); put(0, 8'h55);
        repeat (3) @(posedge clk);
        put(0, 8'h55);
        @(negedge clk); chk("R2 unlocked after idle gap", int'(cfg_mode), 1);

        peek(8'h20, v); chk("R5 id", v, 2);
        peek(8'h21, v); chk("R5 revision", v, 1);
        setr(8'h20, 8'h77);
        peek(8'h20, v); chk("R5 id write ignored", v, 2);

        setr(8'h07, 8'hF4);
        peek(8'h07, v); chk("R6 ldn low bits", v, 4);
        setr(8'h30, 8'h01); setr(8'h60, 8'h03); setr(8'h61, 8'hF8);
        put(0, 8'h70); put(1, 8'h04);
        @(negedge clk);
        chk("R7 irq output after write", int'(dev_irq[4*8 +: 8]), 4);
        chk("R7 base output", int'(dev_base[4*16 +: 16]), 'h03F8);
        chk("R7 active output", int'(dev_active[4]), 1);

        // R3 lock, then R4 writes while locked
        put(0, 8'hAA);
        port_sel = 1'b1;
        @(negedge clk);
        chk("R3 locked", int'(cfg_mode), 0);
        chk("R3 data read locked", int'(rdata), 'hFF);
        put(0, 8'h30); put(1, 8'h00); put(0, 8'h61); put(1, 8'h11);
        @(negedge clk);
        chk("R4 locked writes no effect", int'(dev_base[4*16 +: 16]), 'h03F8);
        put(0, 8'h55); put(0, 8'h55);
        peek(8'h30, v); chk("R4 activate kept", v, 1);

        setr(8'h07, 8'h07); setr(8'h72, 8'h0C);
        peek(8'h72, v); chk("R8 keyboard irq2", v, 'h0C);
        setr(8'h07, 8'h04); setr(8'h72, 8'h05);
        peek(8'h72, v); chk("R8 irq2 absent", v, 0);

        setr(8'h07, 8'h03); setr(8'h74, 8'h02);
        @(negedge clk); chk("R9 parallel dma", int'(dev_dma[3*8 +: 8]), 2);
        setr(8'h07, 8'h05); setr(8'h74, 8'h01);
        @(negedge clk); chk("R9 dma absent output", int'(dev_dma[5*8 +: 8]), 0);
        peek(8'h74, v); chk("R9 dma absent read", v, 0);

        setr(8'h07, 8'h00); setr(8'h90, 8'h0E); setr(8'h91, 8'h5A);
        peek(8'h90, v); chk("R10 mode", v, 'h0E);
        peek(8'h91, v); chk("R10 option", v, 'h5A);
        setr(8'h30, 8'h01);
        setr(8'h07, 8'h01);
        peek(8'h90, v); chk("R10 mode absent", v, 0);

        setr(8'h07, 8'h05); setr(8'h30, 8'h03);
        setr(8'h07, 8'h08); setr(8'h30, 8'h01);
        setr(8'h22, 8'hFF);
        peek(8'h22, v); chk("R11 power view", v, 'h31);

        peek(8'h23, v); chk("R12 unimplemented 23", v, 0);
        peek(8'h50, v); chk("R12 unimplemented 50", v, 0);
        setr(8'h07, 8'h09); setr(8'h30, 8'h01);
        peek(8'h30, v); chk("R6 ldn above range reads 0", v, 0);
        setr(8'h07, 8'h08);
        peek(8'h30, v); chk("R6 device 8 bank", v, 1);

        put(0, 8'hAA);
        repeat (2) @(negedge clk);
        summary();
    end

endmodule